// File: doc/BRIEF.md
# Store Address Generator

This block turns one decoded store instruction into the memory address and, when asked, the updated base register value. A start strobe captures the instruction word, its decoded addressing controls, the base and offset register values and the carry flag. The block then runs two fixed cycles. The address cycle builds the offset, adds it to the base or subtracts it from the base, and issues the address as a write access. The data cycle requests the destination register as the store data, raises the write-data strobe and, if writeback is set, writes the saved sum back to the base register index. A done pulse in the following cycle tells the issuing stage that it may send the next instruction.

The offset can come from four places. It can be a 12-bit immediate, an 8-bit immediate built from two 4-bit fields, the offset register unchanged, or the offset register scaled by a shift or rotate. Pre-indexing puts the combined value on the address bus. Post-indexing puts the plain base on the bus and keeps the combined value for writeback.

There is no back-pressure. The start strobe is a plain control pin and is honoured only when the block is idle. A start raised during the address or data cycle is dropped. The issuing stage must wait for the done pulse. All inputs are captured on the accepted start edge, so they may change in the cycles after it.

Top module: `stagu_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the sequencer returns to idle, and from that edge on addr_vld, wdata_vld, store_rd_req, wb_en and done are all 0. This holds even if start is high at the same edge.
- R2: A start seen high at a clock edge while idle captures all inputs, and addr_vld is 1 in the cycle after that edge. A start raised during the address or data cycle has no effect.
- R3: With am_imm=1 and am_misc=0, the offset is insn[11:0], zero-extended.
- R4: With am_imm=1 and am_misc=1, the offset is {insn[11:8], insn[3:0]}, zero-extended. insn[7:4] has no effect on it.
- R5: With am_imm=0 and am_misc=0, the offset is offs_val shifted by amount insn[11:7], using the kind in insn[6:5]: 00 LSL, 01 LSR, 10 ASR, 11 ROR. LSL with amount 0 leaves offs_val unchanged.
- R6: An amount of 0 with LSR gives an offset of 0. An amount of 0 with ASR gives every bit equal to offs_val[31]. Both act as a shift by 32.
- R7: An amount of 0 with ROR selects RRX, which gives {carry_in, offs_val[31:1]}.
- R8: With am_imm=0 and am_misc=1, the offset is offs_val unshifted, whatever insn[11:5] holds.
- R9: With am_up=1 the sum is base+offset. With am_up=0 it is base-offset, modulo 2^32.
- R10: In the address cycle, addr_o is the sum when am_pre=1 and base_val when am_pre=0.
- R11: In the cycle after addr_vld, wdata_vld and store_rd_req are 1 and store_rd_idx equals insn[15:12].
- R12: In the data cycle with am_wb=1, wb_en=1, wb_idx=insn[19:16] and wb_val equals the address-cycle sum, for both pre- and post-indexing. With am_wb=0, wb_en stays 0.
- R13: done is a single-cycle pulse in the cycle after the data cycle. It never coincides with addr_vld or wdata_vld, and addr_vld never occurs in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a store; accepted only when idle |
| insn | input | 32 | Instruction word (offset, shift, rd, rn fields) |
| am_misc | input | 1 | 1 = misc halfword form, 0 = word/byte form |
| am_imm | input | 1 | 1 = immediate offset, 0 = register offset |
| am_up | input | 1 | 1 = add the offset, 0 = subtract it |
| am_pre | input | 1 | 1 = pre-indexed address, 0 = post-indexed |
| am_wb | input | 1 | Write the sum back to the base register |
| base_val | input | 32 | Base register value |
| offs_val | input | 32 | Offset register value |
| carry_in | input | 1 | Carry flag, used by RRX |
| addr_o | output | 32 | Memory address |
| addr_vld | output | 1 | Address valid for a write access (address cycle) |
| store_rd_req | output | 1 | Request the destination register as store data |
| store_rd_idx | output | 4 | Index of the destination register |
| wdata_vld | output | 1 | Write-data strobe (data cycle) |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index for writeback |
| wb_val | output | 32 | Base writeback value |
| done | output | 1 | Ready for the next instruction |

## Verification
A bad sequencer state shows up as a broken strobe order within one to three cycles. Examples are a data cycle with no address cycle before it, a missing or doubled done, or a second address cycle caused by a start that should have been dropped. A wrong latched operand or offset selection shows up at once as a wrong addr_o in the address cycle. A corrupted sum buffer shows up one cycle later as a wrong wb_val. The scoreboard pairs each accepted store with its own address, store-data request and writeback results. It also flags any address cycle that has no store waiting for it.

// File: rtl/stagu_pkg.sv
package stagu_pkg;

  localparam int RIDX_W  = 4;
  localparam int RD_LSB  = 12;
  localparam int RN_LSB  = 16;
  localparam int SAMT_W  = 5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2
  } sq_state_e;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic misc;
    logic imm;
    logic up;
    logic pre;
    logic wb;
  } am_ctl_t;

endpackage

// File: rtl/stagu_shift.sv
module stagu_shift
  import stagu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]     val,
  input  logic [1:0]        kind,
  input  logic [SAMT_W-1:0] amt,
  input  logic              carry,
  output logic [DW-1:0]     res
);

  logic            amt_zero;
  logic [2*DW-1:0] twice;
  logic [2*DW-1:0] rot_wide;

  assign amt_zero = (amt == '0);
  assign twice    = {val, val};
  assign rot_wide = twice >> amt;

  always_comb begin
    unique case (shift_kind_e'(kind))
      SK_LSL: res = val << amt;
      SK_LSR: res = amt_zero ? '0 : (val >> amt);
      SK_ASR: res = amt_zero ? {DW{val[DW-1]}} : DW'($signed(val) >>> amt);
      default: res = amt_zero ? {carry, val[DW-1:1]} : rot_wide[DW-1:0];
    endcase
  end

endmodule

// File: rtl/stagu_offset.sv
module stagu_offset
  import stagu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [31:0]   insn,
  input  logic          misc,
  input  logic          imm,
  input  logic [DW-1:0] offs,
  input  logic          carry,
  output logic [DW-1:0] off_o
);

  logic [DW-1:0] scaled;
  logic [DW-1:0] imm_wide;

  stagu_shift #(.DW(DW)) u_shift (
    .val   (offs),
    .kind  (insn[6:5]),
    .amt   (insn[11:7]),
    .carry (carry),
    .res   (scaled)
  );

  always_comb begin
    if (misc) imm_wide = DW'({insn[11:8], insn[3:0]});
    else      imm_wide = DW'(insn[11:0]);
  end

  always_comb begin
    if (imm)       off_o = imm_wide;
    else if (misc) off_o = offs;
    else           off_o = scaled;
  end

endmodule

// File: rtl/stagu_adder.sv
module stagu_adder #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);

  logic [DW-1:0] b_eff;

  assign b_eff = b ^ {DW{sub}};
  assign y     = a + b_eff + DW'(sub);

endmodule

// File: rtl/stagu_seq.sv
module stagu_seq
  import stagu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic capture,
  output logic in_addr,
  output logic in_data,
  output logic done
);

  sq_state_e state_q;
  logic      done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == SQ_DATA);
      unique case (state_q)
        SQ_IDLE: if (start) state_q <= SQ_ADDR;
        SQ_ADDR: state_q <= SQ_DATA;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign capture = (state_q == SQ_IDLE) && start;
  assign in_addr = (state_q == SQ_ADDR);
  assign in_data = (state_q == SQ_DATA);
  assign done    = done_q;

endmodule

// File: rtl/stagu_top.sv
module stagu_top
  import stagu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic              am_misc,
  input  logic              am_imm,
  input  logic              am_up,
  input  logic              am_pre,
  input  logic              am_wb,
  input  logic [DW-1:0]     base_val,
  input  logic [DW-1:0]     offs_val,
  input  logic              carry_in,
  output logic [DW-1:0]     addr_o,
  output logic              addr_vld,
  output logic              store_rd_req,
  output logic [RIDX_W-1:0] store_rd_idx,
  output logic              wdata_vld,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [DW-1:0]     wb_val,
  output logic              done
);

  logic          capture, in_addr, in_data;
  logic [31:0]   insn_q;
  am_ctl_t       ctl_q;
  logic [DW-1:0] base_q, offs_q, sum_buf_q;
  logic          carry_q;
  logic [DW-1:0] off_w, op_a, op_b, sum_w;

  stagu_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .capture (capture),
    .in_addr (in_addr),
    .in_data (in_data),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      insn_q  <= '0;
      ctl_q   <= '0;
      base_q  <= '0;
      offs_q  <= '0;
      carry_q <= 1'b0;
    end else if (capture) begin
      insn_q  <= insn;
      ctl_q   <= '{misc: am_misc, imm: am_imm, up: am_up, pre: am_pre, wb: am_wb};
      base_q  <= base_val;
      offs_q  <= offs_val;
      carry_q <= carry_in;
    end
  end

  stagu_offset #(.DW(DW)) u_off (
    .insn  (insn_q),
    .misc  (ctl_q.misc),
    .imm   (ctl_q.imm),
    .offs  (offs_q),
    .carry (carry_q),
    .off_o (off_w)
  );

  // One adder serves both cycles: base +/- offset, then buffer + 0.
  assign op_a = in_data ? sum_buf_q : base_q;
  assign op_b = in_data ? '0 : off_w;

  stagu_adder #(.DW(DW)) u_add (
    .a   (op_a),
    .b   (op_b),
    .sub (in_addr & ~ctl_q.up),
    .y   (sum_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       sum_buf_q <= '0;
    else if (in_addr) sum_buf_q <= sum_w;
  end

  assign addr_vld     = in_addr;
  assign addr_o       = ctl_q.pre ? sum_w : base_q;
  assign wdata_vld    = in_data;
  assign store_rd_req = in_data;
  assign store_rd_idx = insn_q[RD_LSB +: RIDX_W];
  assign wb_en        = in_data & ctl_q.wb;
  assign wb_idx       = insn_q[RN_LSB +: RIDX_W];
  assign wb_val       = sum_w;

endmodule

// File: rtl/stagu_chk.sv
module stagu_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_vld,
  input logic wdata_vld,
  input logic store_rd_req,
  input logic wb_en,
  input logic done
);

  a_r11_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> (wdata_vld && store_rd_req));

  a_r13_done_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_vld |=> done);

  a_r13_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_vld, wdata_vld, done}));

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> !addr_vld);

  a_r12_wb_in_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wdata_vld);

endmodule

bind stagu_top stagu_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_vld     (addr_vld),
  .wdata_vld    (wdata_vld),
  .store_rd_req (store_rd_req),
  .wb_en        (wb_en),
  .done         (done)
);

// File: tb/sim_stagu_top.sv
module sim_stagu_top;

  logic        clk = 1'b0;
  logic        rst_n, start, am_misc, am_imm, am_up, am_pre, am_wb, carry_in;
  logic [31:0] insn, base_val, offs_val;
  logic [31:0] addr_o, wb_val;
  logic        addr_vld, store_rd_req, wdata_vld, wb_en, done;
  logic [3:0]  store_rd_idx, wb_idx;

  always #4 clk = ~clk;

  stagu_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
    .am_misc(am_misc), .am_imm(am_imm), .am_up(am_up), .am_pre(am_pre), .am_wb(am_wb),
    .base_val(base_val), .offs_val(offs_val), .carry_in(carry_in),
    .addr_o(addr_o), .addr_vld(addr_vld), .store_rd_req(store_rd_req),
    .store_rd_idx(store_rd_idx), .wdata_vld(wdata_vld), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val), .done(done)
  );

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  rd;
    logic        wb;
    logic [3:0]  rn;
    logic [31:0] wbv;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  exp_t  cur;
  string cur_tag;
  int    n_chk = 0, n_bad = 0, n_ops = 0, n_done = 0;
  bit    prev_addr = 0, prev_data = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_offset(input logic [31:0] iw, input bit misc, input bit imm,
                                             input logic [31:0] ov, input bit c);
    int amt;
    amt = int'(iw[11:7]);
    if (imm) return misc ? {24'h0, iw[11:8], iw[3:0]} : {20'h0, iw[11:0]};
    if (misc) return ov;
    case (iw[6:5])
      2'b00: return ov << amt;
      2'b01: return (amt == 0) ? 32'h0 : ov >> amt;
      2'b10: return (amt == 0) ? {32{ov[31]}} : 32'($signed(ov) >>> amt);
      default: return (amt == 0) ? {c, ov[31:1]} : ((ov >> amt) | (ov << (32 - amt)));
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] rn, input logic [3:0] rd, input logic [11:0] low);
    return {12'h0, rn, rd, low};
  endfunction

  task automatic run_op(input string tag, input logic [31:0] iw, input bit misc, input bit imm,
                        input bit up, input bit pre, input bit wb, input logic [31:0] b,
                        input logic [31:0] ov, input bit c, input bit intrude);
    exp_t e;
    logic [31:0] off, s;
    off   = exp_offset(iw, misc, imm, ov, c);
    s     = up ? b + off : b - off;
    e.addr = pre ? s : b;
    e.rd  = iw[15:12];
    e.wb  = wb;
    e.rn  = iw[19:16];
    e.wbv = s;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    n_ops++;
    @(negedge clk);
    insn = iw; am_misc = misc; am_imm = imm; am_up = up; am_pre = pre; am_wb = wb;
    base_val = b; offs_val = ov; carry_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    insn = ~iw; base_val = ~b; offs_val = ~ov; am_pre = ~pre; am_up = ~up; carry_in = ~c;
    if (intrude) begin
      start = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_vld) begin
        if (q_exp.size() == 0) begin
          chk(1'b0, "R2 spurious address cycle", addr_o, 32'h0);
        end else begin
          cur = q_exp.pop_front();
          cur_tag = q_tag.pop_front();
          chk(addr_o == cur.addr, {cur_tag, " addr"}, addr_o, cur.addr);
        end
      end
      if (wdata_vld) begin
        chk(prev_addr, "R11 data cycle after address", 32'(prev_addr), 32'h1);
        chk(store_rd_req && store_rd_idx == cur.rd, {cur_tag, " R11 rd"}, 32'(store_rd_idx), 32'(cur.rd));
        chk(wb_en == cur.wb, {cur_tag, " R12 wb_en"}, 32'(wb_en), 32'(cur.wb));
        if (cur.wb) begin
          chk(wb_idx == cur.rn, {cur_tag, " R12 wb_idx"}, 32'(wb_idx), 32'(cur.rn));
          chk(wb_val == cur.wbv, {cur_tag, " R12 wb_val"}, wb_val, cur.wbv);
        end
      end
      if (done) begin
        chk(prev_data, "R13 done after data", 32'(prev_data), 32'h1);
        n_done++;
      end
      prev_addr <= addr_vld;
      prev_data <= wdata_vld;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_done, n_ops);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; insn = '0; am_misc = 0; am_imm = 0; am_up = 0;
    am_pre = 0; am_wb = 0; base_val = '0; offs_val = '0; carry_in = 0;
    repeat (3) @(negedge clk);
    chk({addr_vld, wdata_vld, store_rd_req, wb_en, done} == 5'b0, "R1 reset strobes",
        32'({addr_vld, wdata_vld, store_rd_req, wb_en, done}), 32'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_vld, "R1 start under reset dropped", 32'(addr_vld), 32'h0);
    @(negedge clk);
    chk(!addr_vld && !done, "R1 idle after reset", 32'({addr_vld, done}), 32'h0);

    // R3 R9 R10 R12: word/byte immediate, pre, up, writeback
    run_op("R3 R9 R10 imm12 pre up", mk(4'd2, 4'd5, 12'h123), 0, 1, 1, 1, 1, 32'h1000_0000, 32'h0, 0, 0);
    run_op("R3 R10 imm12 post down", mk(4'd7, 4'd1, 12'h040), 0, 1, 0, 0, 1, 32'h0000_8000, 32'h0, 0, 0);
    run_op("R3 imm12 max no wb", mk(4'd3, 4'd9, 12'hFFF), 0, 1, 1, 1, 0, 32'h0000_0001, 32'h0, 0, 0);
    run_op("R4 misc imm split", mk(4'd4, 4'd6, 12'hAF5), 1, 1, 1, 1, 1, 32'h2000_0000, 32'h0, 0, 0);
    run_op("R5 LSL 3", mk(4'd1, 4'd2, {5'd3, 2'b00, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h100, 32'h11, 0, 0);
    run_op("R5 LSL 0", mk(4'd1, 4'd2, {5'd0, 2'b00, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h100, 32'h8000_0011, 0, 0);
    run_op("R5 LSR 4", mk(4'd8, 4'd3, {5'd4, 2'b01, 1'b0, 4'd0}), 0, 0, 0, 1, 1, 32'h5000, 32'hF0F0, 0, 0);
    run_op("R6 LSR 0", mk(4'd8, 4'd3, {5'd0, 2'b01, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h5000, 32'hFFFF_FFFF, 0, 0);
    run_op("R6 ASR 0", mk(4'd9, 4'd4, {5'd0, 2'b10, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h10, 32'h8000_0000, 0, 0);
    run_op("R5 ASR 7", mk(4'd9, 4'd4, {5'd7, 2'b10, 1'b0, 4'd0}), 0, 0, 1, 0, 1, 32'h10, 32'h8000_1000, 0, 0);
    run_op("R5 ROR 8", mk(4'd10, 4'd11, {5'd8, 2'b11, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h0, 32'h1234_56AB, 0, 0);
    run_op("R7 RRX carry1", mk(4'd10, 4'd11, {5'd0, 2'b11, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h0, 32'h0000_0003, 1, 0);
    run_op("R7 RRX carry0", mk(4'd12, 4'd13, {5'd0, 2'b11, 1'b0, 4'd0}), 0, 0, 1, 1, 1, 32'h0, 32'h8000_0002, 0, 0);
    run_op("R8 misc reg unshifted", mk(4'd14, 4'd15, {5'd9, 2'b11, 1'b0, 4'd0}), 1, 0, 1, 1, 1, 32'h40, 32'h0000_0F01, 1, 0);
    run_op("R9 subtract wraps", mk(4'd5, 4'd0, 12'h010), 0, 1, 0, 1, 1, 32'h0000_0004, 32'h0, 0, 0);
    run_op("R2 start while busy ignored", mk(4'd6, 4'd7, 12'h008), 0, 1, 1, 0, 1, 32'h3000_0000, 32'h0, 0, 1);
    repeat (4) @(negedge clk);

    chk(q_exp.size() == 0, "R2 all stores consumed", 32'(q_exp.size()), 32'h0);
    chk(n_done == n_ops, "R13 one done per store", 32'(n_done), 32'(n_ops));
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule